// File: doc/BRIEF.md
# SPI serial memory command engine

This block is the slave side of a byte-wide serial memory on an SPI bus (mode 0). The host lowers the chip select and clocks in an 8-bit opcode, then a 16-bit address and data bytes when the command needs them. Read data and status leave on the serial output. The array is an internal RAM of `2**ADDR_W` bytes. The default of 11 keeps elaboration small; setting `ADDR_W = 13` gives the 8K x 8 organisation. Only the low `ADDR_W` address bits are used. A write-enable latch guards every change to the array and to the status register. A committed change starts an internal write cycle of `BUSY_CYCLES` system clocks, and during that cycle the engine answers only status reads.

The SPI pins are sampled in the system clock domain and SCK edges are found by comparing each sample with the one before. A low hold input blanks those edges and floats the output, so the transfer continues from the same bit once hold rises again. SCK may also stop for any length of time.

The command state machine has seven states:
- OPCODE collects the first byte.
- From OPCODE it goes to ADDR for an array read, or for an array write while the latch is set. It goes to SRD for a status read and to SWR for a status write while the latch is set. Any other case goes to DROP.
- ADDR goes to WDATA or RDATA after 16 bits.
- SRD, SWR, WDATA, RDATA and DROP hold until the chip select rises.
- A chip-select rise returns every state to OPCODE.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset the output enable is low and a status read returns 0x00.
- R2: SI is sampled on SCK rising edges, MSB first, starting with the first rise after CS falls. The opcodes are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. Any other opcode leaves the output floating until CS rises.
- R3: SO changes only after an SCK falling edge. `so_oe` is high only while CS is low, hold is high and read data or status is being returned.
- R4: An array read returns the byte at the low `ADDR_W` bits of the 16-bit address, then the following bytes, wrapping from the top of the array to 0.
- R5: An array write needs the latch set when its opcode ends. Its data bytes wrap inside the 32-byte aligned page. It is committed only when CS rises after at least one whole byte with no partial byte pending. Otherwise nothing changes and the latch keeps its value.
- R6: The status byte is {protect-enable bit 7, zeros 6:4, block bits 3:2, latch bit 1, busy bit 0}. It reads 0xFF while a write cycle runs.
- R7: 0x06 sets the latch and 0x04 clears it. The end of every write cycle clears it, and busy holds for the write cycle after a commit.
- R8: A status write needs the latch set. It keeps bits 7, 3 and 2 of its last whole data byte and commits when CS rises on a byte boundary.
- R9: While a write cycle runs, every opcode except 0x05 is ignored.
- R10: While hold is low, SCK edges are ignored and the output floats. After hold rises the transfer resumes at the same bit.
- R11: SCK may stop for any number of clocks mid-byte without losing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |

## Verification
A wrong command state or bit counter shows within one byte. The next read returns shifted or foreign bits, or `so_oe` rises or falls on the wrong bit. A lost latch or page offset stays hidden until a later array read returns the wrong byte at some address. A stuck busy flag shows at once as a 0xFF status and as reads that never drive the output.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    typedef enum logic [2:0] {
        ST_OPCODE, ST_ADDR, ST_WDATA, ST_RDATA, ST_SRD, ST_SWR, ST_DROP
    } cmd_state_e;

    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_CLR_WEL  = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_ARRAY = 8'h03;
    localparam logic [7:0] OP_WR_ARRAY = 8'h02;
endpackage

// File: rtl/spi_pin_edges.sv
module spi_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;
    logic active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // hold blanks edges, sck_q keeps tracking so release makes no edge
    assign active   = !cs_n && hold_n;
    assign sck_rise = active && sck && !sck_q;
    assign sck_fall = active && !sck && sck_q;
    assign cs_rise  = cs_n && !cs_q;
endmodule

// File: rtl/spi_busy_timer.sv
module spi_busy_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CW'(BUSY_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/spi_page_store.sv
module spi_page_store #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    push,
    input  logic [OFF_W-1:0]        push_off,
    input  logic [7:0]              push_data,
    input  logic                    commit,
    input  logic [ADDR_W-OFF_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);
    logic [7:0]              mem_q [DEPTH];
    logic [7:0]              page_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]   mask_q;
    logic                    drain_q;
    logic [OFF_W-1:0]        idx_q;
    logic [ADDR_W-OFF_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            drain_q <= 1'b0;
            idx_q   <= '0;
            base_q  <= '0;
        end else if (commit) begin
            drain_q <= 1'b1;
            idx_q   <= '0;
            base_q  <= commit_page;
        end else if (drain_q) begin
            mask_q[idx_q] <= 1'b0;
            idx_q         <= idx_q + 1'b1;
            if (idx_q == OFF_W'(PAGE_BYTES - 1)) drain_q <= 1'b0;
        end else if (clear) begin
            mask_q <= '0;
        end else if (push) begin
            mask_q[push_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) page_q[push_off] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (drain_q && mask_q[idx_q]) mem_q[{base_q, idx_q}] <= page_q[idx_q];
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck_rise,
    input  logic                    sck_fall,
    input  logic                    cs_rise,
    input  logic                    cs_n,
    input  logic                    hold_n,
    input  logic                    si,
    input  logic                    busy,
    input  logic                    wr_done,
    input  logic [7:0]              rd_data,
    output logic                    so,
    output logic                    so_oe,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    pg_clear,
    output logic                    pg_push,
    output logic [OFF_W-1:0]        pg_off,
    output logic [ADDR_W-OFF_W-1:0] pg_page,
    output logic                    pg_commit,
    output logic                    sr_commit,
    output logic [2:0]              bit_cnt,
    output logic                    wel
);
    cmd_state_e        state_q, state_d;
    logic [2:0]        cnt_q;
    logic [6:0]        rx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              second_q, to_write_q, got_q;
    logic              wel_q, wpen_q;
    logic [1:0]        bp_q;
    logic [2:0]        sr_keep_q;
    logic              so_q;
    logic [7:0]        rx_byte, status, out_byte;
    logic              byte_done, out_phase;

    assign rx_byte   = {rx_q, si};
    assign byte_done = sck_rise && (cnt_q == 3'd7);
    assign status    = busy ? 8'hFF : {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
    assign out_phase = (state_q == ST_RDATA) || (state_q == ST_SRD);
    assign out_byte  = (state_q == ST_SRD) ? status : rd_data;

    // next state and one-cycle strobes
    always_comb begin
        state_d   = state_q;
        pg_clear  = 1'b0;
        pg_push   = 1'b0;
        pg_commit = 1'b0;
        sr_commit = 1'b0;
        if (cs_rise) begin
            state_d   = ST_OPCODE;
            pg_commit = (state_q == ST_WDATA) && (cnt_q == 3'd0) && got_q;
            sr_commit = (state_q == ST_SWR) && (cnt_q == 3'd0) && got_q;
        end else if (byte_done) begin
            unique case (state_q)
                ST_OPCODE: begin
                    state_d = ST_DROP;
                    if (rx_byte == OP_RD_STAT) begin
                        state_d = ST_SRD;
                    end else if (!busy) begin
                        if (rx_byte == OP_RD_ARRAY) state_d = ST_ADDR;
                        if (wel_q && rx_byte == OP_WR_ARRAY) begin
                            state_d  = ST_ADDR;
                            pg_clear = 1'b1;
                        end
                        if (wel_q && rx_byte == OP_WR_STAT) state_d = ST_SWR;
                    end
                end
                ST_ADDR:  if (second_q) state_d = to_write_q ? ST_WDATA : ST_RDATA;
                ST_WDATA: pg_push = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rx_q       <= '0;
            addr_q     <= '0;
            second_q   <= 1'b0;
            to_write_q <= 1'b0;
            got_q      <= 1'b0;
            wel_q      <= 1'b0;
            wpen_q     <= 1'b0;
            bp_q       <= '0;
            sr_keep_q  <= '0;
            so_q       <= 1'b0;
        end else begin
            if (wr_done) wel_q <= 1'b0;
            if (cs_rise) begin
                cnt_q    <= '0;
                second_q <= 1'b0;
                got_q    <= 1'b0;
                if (sr_commit) {wpen_q, bp_q} <= sr_keep_q;
            end else if (sck_rise) begin
                cnt_q <= cnt_q + 1'b1;
                rx_q  <= rx_byte[6:0];
                if (state_q == ST_ADDR) addr_q <= {addr_q[ADDR_W-2:0], si};
                if (byte_done) begin
                    unique case (state_q)
                        ST_OPCODE: begin
                            to_write_q <= (rx_byte == OP_WR_ARRAY);
                            if (!busy && rx_byte == OP_SET_WEL) wel_q <= 1'b1;
                            if (!busy && rx_byte == OP_CLR_WEL) wel_q <= 1'b0;
                        end
                        ST_ADDR:  second_q <= 1'b1;
                        ST_WDATA: begin
                            addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + 1'b1;
                            got_q             <= 1'b1;
                        end
                        ST_RDATA: addr_q <= addr_q + 1'b1;
                        ST_SWR: begin
                            sr_keep_q <= {rx_byte[7], rx_byte[3:2]};
                            got_q     <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && out_phase) so_q <= out_byte[~cnt_q];
        end
    end

    assign so       = so_q;
    assign so_oe    = !cs_n && hold_n && out_phase;
    assign mem_addr = addr_q;
    assign pg_off   = addr_q[OFF_W-1:0];
    assign pg_page  = addr_q[ADDR_W-1:OFF_W];
    assign bit_cnt  = cnt_q;
    assign wel      = wel_q;
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic                    sck_rise, sck_fall, cs_rise;
    logic                    busy, wr_done, timer_start;
    logic                    pg_clear, pg_push, pg_commit, sr_commit, wel;
    logic [OFF_W-1:0]        pg_off;
    logic [ADDR_W-OFF_W-1:0] pg_page;
    logic [ADDR_W-1:0]       mem_addr;
    logic [7:0]              rd_data;
    logic [2:0]              bit_cnt;

    assign timer_start = pg_commit || sr_commit;

    spi_pin_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(timer_start), .busy(busy), .done(wr_done)
    );

    spi_page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(pg_clear), .push(pg_push),
        .push_off(pg_off), .push_data({u_fsm.rx_q, si}), .commit(pg_commit),
        .commit_page(pg_page), .rd_addr(mem_addr), .rd_data(rd_data)
    );

    spi_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_n(cs_n), .hold_n(hold_n), .si(si), .busy(busy),
        .wr_done(wr_done), .rd_data(rd_data), .so(so), .so_oe(so_oe),
        .mem_addr(mem_addr), .pg_clear(pg_clear), .pg_push(pg_push),
        .pg_off(pg_off), .pg_page(pg_page), .pg_commit(pg_commit),
        .sr_commit(sr_commit), .bit_cnt(bit_cnt), .wel(wel)
    );
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       hold_n,
    input logic       so,
    input logic       so_oe,
    input logic       sck_fall,
    input logic [2:0] bit_cnt,
    input logic       busy,
    input logic       timer_start,
    input logic       pg_commit,
    input logic       sr_commit,
    input logic       wel
);
    assert_so_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !hold_n) |-> !so_oe);

    assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so));

    assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && !cs_n) |=> $stable(bit_cnt));

    assert_no_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(pg_commit || sr_commit));

    assert_wel_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start |=> busy);

    assert_commit_on_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_commit || sr_commit) |-> cs_n);
endmodule

bind spi_mem_engine spi_mem_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so(so),
    .so_oe(so_oe), .sck_fall(sck_fall), .bit_cnt(bit_cnt), .busy(busy),
    .timer_start(timer_start), .pg_commit(pg_commit), .sr_commit(sr_commit),
    .wel(wel)
);

// File: tb/spi_mem_engine_bench.sv
module spi_mem_engine_bench;
    localparam int AW   = 11;
    localparam int BUSY = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    int   checks = 0, fails = 0;
    bit   finished = 1'b0;
    logic [7:0] model_mem [0:(1<<AW)-1];

    always #2 clk = ~clk;

    spi_mem_engine #(.ADDR_W(AW), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) u_spi_mem_engine (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic bit_x(input logic b, input logic exp_oe, input string tag, output logic r);
        @(negedge clk); sck = 1'b0; si = b;
        repeat (4) @(negedge clk);
        r = so;
        chk({tag, " oe"}, {7'd0, so_oe}, {7'd0, exp_oe});
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, input logic rd, input string tag, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bit_x(tx[i], rd, tag, r);
            rx[i] = r;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        @(negedge clk); sck = 1'b0; repeat (2) @(negedge clk);
        cs_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op, input string tag);
        logic [7:0] r;
        cs_lo(); xbyte(op, 1'b0, tag, r); cs_hi();
    endtask

    task automatic rdsr(input string tag, output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); xbyte(8'h05, 1'b0, tag, r); xbyte(8'h00, 1'b1, tag, s); cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr("R6 poll", s);
            if (!s[0]) break;
        end
    endtask

    task automatic send_addr(input logic [15:0] a, input string tag);
        logic [7:0] r;
        xbyte(a[15:8], 1'b0, tag, r); xbyte(a[7:0], 1'b0, tag, r);
    endtask

    task automatic write_page(input logic [15:0] a, input int n, input logic [7:0] seed, input logic wait_done);
        logic [7:0] r;
        cmd1(8'h06, "R7 wren");
        cs_lo(); xbyte(8'h02, 1'b0, "R5 wr op", r); send_addr(a, "R5 wr addr");
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 7);
            xbyte(d, 1'b0, "R5 wr data", r);
            model_mem[{a[AW-1:5], 5'((a[4:0]) + i)}] = d;
        end
        cs_hi();
        if (wait_done) wait_idle();
    endtask

    task automatic read_chk(input logic [15:0] a, input int n, input string tag);
        logic [7:0] r;
        cs_lo(); xbyte(8'h03, 1'b0, tag, r); send_addr(a, tag);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, 1'b1, tag, r);
            chk(tag, r, model_mem[AW'(a + 16'(i))]);
        end
        cs_hi();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R11 watchdog got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, r, b;
        logic bt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 so_oe", {7'd0, so_oe}, 8'h00);
        rdsr("R1 status", s); chk("R1 status", s, 8'h00);

        // R7 latch set and clear
        cmd1(8'h06, "R7 wren"); rdsr("R7", s); chk("R7 wel set", s, 8'h02);
        cmd1(8'h04, "R7 wrdi"); rdsr("R7", s); chk("R7 wel clr", s, 8'h00);

        // R2 R4 R5 basic write then read, high address bits ignored
        write_page(16'h0100, 8, 8'h11, 1'b1);
        rdsr("R7", s); chk("R7 wel cleared after write", s, 8'h00);
        read_chk(16'h0100, 8, "R4 read");
        read_chk(16'hF900, 2, "R4 high bits");

        // R5 page wrap
        write_page(16'h023E, 4, 8'h40, 1'b1);
        read_chk(16'h023E, 2, "R5 page tail");
        read_chk(16'h0220, 2, "R5 page wrap");

        // R4 sequential read wraps at array end
        write_page(16'h07FE, 2, 8'h90, 1'b1);
        write_page(16'h0000, 2, 8'hA0, 1'b1);
        read_chk(16'h07FE, 4, "R4 array wrap");

        // R5 write without latch ignored
        cs_lo(); xbyte(8'h02, 1'b0, "R5 nowel", r); send_addr(16'h0100, "R5 nowel");
        xbyte(8'hAA, 1'b0, "R5 nowel", r); cs_hi();
        rdsr("R5", s); chk("R5 nowel status", s, 8'h00);
        read_chk(16'h0100, 1, "R5 nowel data");

        // R5 partial byte abandons the write, latch kept
        cmd1(8'h06, "R7 wren");
        cs_lo(); xbyte(8'h02, 1'b0, "R5 partial", r); send_addr(16'h0101, "R5 partial");
        for (int i = 0; i < 4; i++) bit_x(1'b1, 1'b0, "R5 partial", bt);
        cs_hi();
        rdsr("R5", s); chk("R5 partial status", s, 8'h02);
        read_chk(16'h0101, 1, "R5 partial data");
        cmd1(8'h04, "R7 wrdi");

        // R6 R9 behaviour during a write cycle
        write_page(16'h0300, 1, 8'h5C, 1'b0);
        rdsr("R6", s); chk("R6 busy status", s, 8'hFF);
        cs_lo(); xbyte(8'h03, 1'b0, "R9 read busy", r); send_addr(16'h0100, "R9 read busy");
        xbyte(8'h00, 1'b0, "R9 read busy", r); cs_hi();
        cs_lo(); xbyte(8'h02, 1'b0, "R9 write busy", r); send_addr(16'h0100, "R9 write busy");
        xbyte(8'h33, 1'b0, "R9 write busy", r); cs_hi();
        wait_idle();
        rdsr("R7", s); chk("R7 wel after cycle", s, 8'h00);
        read_chk(16'h0100, 1, "R9 data kept");
        read_chk(16'h0300, 1, "R5 busy write data");

        // R8 status write
        cmd1(8'h06, "R8 wren");
        cs_lo(); xbyte(8'h01, 1'b0, "R8", r); xbyte(8'hFF, 1'b0, "R8", r); cs_hi();
        wait_idle();
        rdsr("R8", s); chk("R8 status kept bits", s, 8'h8C);
        cs_lo(); xbyte(8'h01, 1'b0, "R8", r); xbyte(8'h00, 1'b0, "R8", r); cs_hi();
        rdsr("R8", s); chk("R8 status nowel", s, 8'h8C);

        // R2 unknown opcode keeps output floating
        cs_lo(); xbyte(8'hFF, 1'b0, "R2 bad op", r); xbyte(8'h00, 1'b0, "R2 bad op", r); cs_hi();

        // R10 hold mid-byte, R11 stopped clock
        cs_lo(); xbyte(8'h03, 1'b0, "R10", r); send_addr(16'h0100, "R10");
        xbyte(8'h00, 1'b1, "R10", r); chk("R10 byte0", r, model_mem[11'h100]);
        for (int i = 7; i >= 5; i--) begin bit_x(1'b0, 1'b1, "R10", bt); b[i] = bt; end
        @(negedge clk); hold_n = 1'b0; repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b0; repeat (3) @(negedge clk);
            chk("R10 so_oe in hold", {7'd0, so_oe}, 8'h00);
            sck = 1'b1; repeat (3) @(negedge clk);
        end
        hold_n = 1'b1; repeat (2) @(negedge clk);
        for (int i = 4; i >= 3; i--) begin bit_x(1'b0, 1'b1, "R10", bt); b[i] = bt; end
        repeat (500) @(negedge clk);
        for (int i = 2; i >= 0; i--) begin bit_x(1'b0, 1'b1, "R11", bt); b[i] = bt; end
        chk("R10 R11 byte1", b, model_mem[11'h101]);
        xbyte(8'h00, 1'b1, "R10", r); chk("R10 byte2", r, model_mem[11'h102]);
        cs_hi();
        chk("R3 so_oe cs high", {7'd0, so_oe}, 8'h00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule